// File: doc/BRIEF.md
# Shared-Multiplier PID Controller Core

This core produces one discrete PID control output per sample. It uses exactly one signed multiplier and one 32-bit adder. A short sequencer steps both units through a fixed four-stage schedule. One-hot operand-enable lines pick what each unit sees in each stage. A host loads the three signed 8-bit gains with an init pulse and then presents one signed 8-bit error sample per control period together with a start pulse. It reads the 32-bit control value when `done` pulses.

Between samples the core keeps the previous error Em and the running error sum SumEm. For each sample En it forms u = Kp·En + Ki·S + Kd·(En − Em). Here S = sat(En + SumEm) and sat clamps to the signed SUM_W-bit range. After each sample, SumEm takes the value S and Em takes the value En. The stage order is as follows:
- Stage 0: Kp·En and En+SumEm.
- Stage 1: −1·Em.
- Stage 2: Ki·S and En+(−Em).
- Stage 3: Kd·(En−Em) and P+I.
- Closing add: (P+I)+D.

Top module: `pid_mux_core`

## Requirements
- R1: A synchronous active-high `rst` clears the gains, Em, SumEm and the result register, and leaves the sequencer idle. After reset, `busy`=0, `done`=0, `stage_oe`=0 and `u_out`=0. A sample taken before any gain load therefore yields u=0.
- R2: `ld_gains` while idle stores `kp_in`/`ki_in`/`kd_in` as signed gains and zeroes Em and SumEm. While `busy` is high it has no effect. It takes priority over `start` in the same cycle.
- R3: A completed sample sets `u_out` to Kp·En + Ki·S + Kd·(En − Em) as a signed 32-bit value.
- R4: A `start` sampled while idle makes `busy` high from the next cycle for exactly five cycles. `done` is high for one cycle in the cycle where `busy` has just fallen.
- R5: `start` while `busy` is high has no effect. The run in progress keeps its sample and its length, and no second run follows.
- R6: `u_out` holds its value in every cycle except the one where `done` rises with a new result.
- R7: `err_in` is two's complement and is sign-extended before use, so negative errors (0x80 = −128) enter the formula with their signed value.
- R8: S saturates at +(2^(SUM_W−1)−1) and −2^(SUM_W−1) instead of wrapping. With SUM_W=12 these limits are 2047 and −2048.
- R9: During the four run stages `stage_oe` is one-hot, with bit k set in stage k (stage code 00→0001, 01→0010, 10→0100, 11→1000). It is 0000 in the closing add stage and while idle.
- R10: After each sample, SumEm becomes S and Em becomes En. Both are used by the next sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_gains | input | 1 | Load gains and clear history (idle only) |
| kp_in | input | GAIN_W | Proportional gain, signed |
| ki_in | input | GAIN_W | Integral gain, signed |
| kd_in | input | GAIN_W | Derivative gain, signed |
| start | input | 1 | Begin one sample (idle only) |
| err_in | input | ERR_W | Error sample, signed |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| stage_oe | output | 4 | One-hot operand-enable lines |
| u_out | output | ACC_W | Registered control output, signed |

## Verification
The assertions check the following on every cycle:
- The operand-enable lines are never more than one-hot, and they are quiet while idle.
- Each run lasts exactly five cycles and ends with a single-cycle `done`.
- `u_out` changes only when a result lands.
- Reset leaves the core idle and cleared.

Only the bench scenarios can show the arithmetic: the three-term value against an integer model, the sign handling of negative samples, the clamping of the running sum at both limits, and the carry of history from one sample to the next. The same holds for the proof that a gain load or a start issued mid-run leaves both the current result and later results untouched.

// File: rtl/pid_mux_pkg.sv
package pid_mux_pkg;
  localparam int PID_STAGES = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;
endpackage

// File: rtl/pid_mux_seq.sv
module pid_mux_seq
  import pid_mux_pkg::*;
#(
  parameter int STAGES = PID_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic              busy,
  output logic              fin,
  output logic [STAGES-1:0] oe
);
  localparam int SW = $clog2(STAGES);

  phase_t        ph;
  logic [SW-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      stg <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (go) begin
          ph  <= PH_RUN;
          stg <= '0;
        end
        PH_RUN: begin
          if (stg == SW'(STAGES - 1)) ph <= PH_FIN;
          else                        stg <= stg + 1'b1;
        end
        PH_FIN:  ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // decode of the stage code into one enable line per stage
  for (genvar gi = 0; gi < STAGES; gi++) begin : g_oe
    assign oe[gi] = (ph == PH_RUN) && (stg == SW'(gi));
  end

  assign busy = (ph != PH_IDLE);
  assign fin  = (ph == PH_FIN);
endmodule

// File: rtl/pid_mux_mul.sv
module pid_mux_mul #(
  parameter int GAIN_W = 8,
  parameter int OPB_W  = 24,
  parameter int ACC_W  = 32
) (
  input  logic signed [GAIN_W-1:0] a,
  input  logic signed [OPB_W-1:0]  b,
  output logic signed [ACC_W-1:0]  y
);
  localparam int PW = GAIN_W + OPB_W;

  logic signed [PW-1:0] full;

  assign full = a * b;
  assign y    = ACC_W'(full);
endmodule

// File: rtl/pid_mux_add.sv
module pid_mux_add #(
  parameter int ACC_W = 32
) (
  input  logic signed [ACC_W-1:0] a,
  input  logic signed [ACC_W-1:0] b,
  output logic signed [ACC_W-1:0] y
);
  assign y = a + b;
endmodule

// File: rtl/pid_mux_core.sv
module pid_mux_core
  import pid_mux_pkg::*;
#(
  parameter int GAIN_W = 8,
  parameter int ERR_W  = 8,
  parameter int OPB_W  = 24,
  parameter int ACC_W  = 32,
  parameter int SUM_W  = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_gains,
  input  logic [GAIN_W-1:0]     kp_in,
  input  logic [GAIN_W-1:0]     ki_in,
  input  logic [GAIN_W-1:0]     kd_in,
  input  logic                  start,
  input  logic [ERR_W-1:0]      err_in,
  output logic                  busy,
  output logic                  done,
  output logic [PID_STAGES-1:0] stage_oe,
  output logic [ACC_W-1:0]      u_out
);
  localparam int SMAXI = (1 << (SUM_W - 1)) - 1;
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'(SMAXI);
  localparam logic signed [ACC_W-1:0] SMIN = ACC_W'(-SMAXI - 1);

  logic signed [GAIN_W-1:0] kp_r, ki_r, kd_r;
  logic signed [OPB_W-1:0]  en_r, em_r, sum_r, s_r, n_r, d0_r;
  logic signed [ACC_W-1:0]  p_r, i_r, dt_r, pi_r, u_r;
  logic                     done_r;

  logic                     fin, go, ld_ok;
  logic [PID_STAGES-1:0]    oe;
  logic signed [GAIN_W-1:0] mul_a;
  logic signed [OPB_W-1:0]  mul_b;
  logic signed [ACC_W-1:0]  mul_y, add_a, add_b, add_y;

  function automatic logic signed [OPB_W-1:0] sat_sum(input logic signed [ACC_W-1:0] x);
    if (x > SMAX)      return OPB_W'(SMAX);
    else if (x < SMIN) return OPB_W'(SMIN);
    else               return OPB_W'(x);
  endfunction

  assign ld_ok = ld_gains && !busy;
  assign go    = start && !busy && !ld_gains;

  pid_mux_seq #(.STAGES(PID_STAGES)) u_seq (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .busy(busy),
    .fin (fin),
    .oe  (oe)
  );

  pid_mux_mul #(.GAIN_W(GAIN_W), .OPB_W(OPB_W), .ACC_W(ACC_W)) u_mul (
    .a(mul_a),
    .b(mul_b),
    .y(mul_y)
  );

  pid_mux_add #(.ACC_W(ACC_W)) u_add (
    .a(add_a),
    .b(add_b),
    .y(add_y)
  );

  // operand steering by the enable lines
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    add_a = '0;
    add_b = '0;
    if (oe[0]) begin
      mul_a = kp_r;
      mul_b = en_r;
      add_a = ACC_W'(en_r);
      add_b = ACC_W'(sum_r);
    end
    if (oe[1]) begin
      mul_a = '1;               // constant -1
      mul_b = em_r;
    end
    if (oe[2]) begin
      mul_a = ki_r;
      mul_b = s_r;
      add_a = ACC_W'(en_r);
      add_b = ACC_W'(n_r);
    end
    if (oe[3]) begin
      mul_a = kd_r;
      mul_b = d0_r;
      add_a = p_r;
      add_b = i_r;
    end
    if (fin) begin
      add_a = pi_r;
      add_b = dt_r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kp_r   <= '0;
      ki_r   <= '0;
      kd_r   <= '0;
      en_r   <= '0;
      em_r   <= '0;
      sum_r  <= '0;
      s_r    <= '0;
      n_r    <= '0;
      d0_r   <= '0;
      p_r    <= '0;
      i_r    <= '0;
      dt_r   <= '0;
      pi_r   <= '0;
      u_r    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= fin;
      if (ld_ok) begin
        kp_r  <= $signed(kp_in);
        ki_r  <= $signed(ki_in);
        kd_r  <= $signed(kd_in);
        em_r  <= '0;
        sum_r <= '0;
      end
      if (go) en_r <= OPB_W'($signed(err_in));
      if (oe[0]) begin
        p_r <= mul_y;
        s_r <= sat_sum(add_y);
      end
      if (oe[1]) n_r <= OPB_W'(mul_y);
      if (oe[2]) begin
        i_r  <= mul_y;
        d0_r <= OPB_W'(add_y);
      end
      if (oe[3]) begin
        dt_r <= mul_y;
        pi_r <= add_y;
      end
      if (fin) begin
        u_r   <= add_y;
        em_r  <= en_r;
        sum_r <= s_r;
      end
    end
  end

  assign done     = done_r;
  assign stage_oe = oe;
  assign u_out    = u_r;
endmodule

// File: rtl/pid_mux_chk.sv
module pid_mux_chk
  import pid_mux_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  done,
  input logic [PID_STAGES-1:0] stage_oe,
  input logic [ACC_W-1:0]      u_out
);
  logic [2:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && u_out == '0 && stage_oe == '0));

  // R9
  oe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_oe));

  // R9
  oe_idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (stage_oe == '0));

  // R4 R5
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt <= 3'd4));

  // R4 R5
  run_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && $past(run_cnt) == 3'd4));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  u_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(u_out)));
endmodule

bind pid_mux_core pid_mux_chk #(.ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .stage_oe(stage_oe),
  .u_out   (u_out)
);

// File: tb/pid_mux_core_tb.sv
module pid_mux_core_tb;
  localparam int SUM_W = 12;
  localparam int SMAXI = (1 << (SUM_W - 1)) - 1;
  localparam int NTAB  = 12;
  localparam logic signed [7:0] ERR_TAB [NTAB] =
    '{8'sd10, 8'sd10, -8'sd5, 8'sd127, -8'sd128, 8'sd0,
      8'sd33, -8'sd1, 8'sd64, -8'sd77, 8'sd2, -8'sd128};

  logic        clk = 1'b0;
  logic        rst, ld_gains, start, busy, done;
  logic [7:0]  kp_in, ki_in, kd_in, err_in;
  logic [3:0]  stage_oe;
  logic [31:0] u_out;

  int n_tests = 0, n_fail = 0;
  int m_kp, m_ki, m_kd, m_em, m_sm;
  bit finished = 0;

  always #5 clk = ~clk;

  pid_mux_core #(.SUM_W(SUM_W)) u_dut (
    .clk(clk), .rst(rst), .ld_gains(ld_gains),
    .kp_in(kp_in), .ki_in(ki_in), .kd_in(kd_in),
    .start(start), .err_in(err_in),
    .busy(busy), .done(done), .stage_oe(stage_oe), .u_out(u_out)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_step(int e);
    int s, u;
    s = e + m_sm;
    if (s > SMAXI) s = SMAXI;
    if (s < -SMAXI - 1) s = -SMAXI - 1;
    u = m_kp * e + m_ki * s + m_kd * (e - m_em);
    m_em = e;
    m_sm = s;
    return u;
  endfunction

  task automatic load(int kp, int ki, int kd);
    @(negedge clk);
    kp_in = 8'(kp); ki_in = 8'(ki); kd_in = 8'(kd); ld_gains = 1'b1;
    @(negedge clk);
    ld_gains = 1'b0;
    m_kp = kp; m_ki = ki; m_kd = kd; m_em = 0; m_sm = 0;
  endtask

  // one sample; checks latency, enable sequence and result
  task automatic sample(int e, string req);
    int cnt, exp;
    bit oe_ok;
    @(negedge clk);
    err_in = 8'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    oe_ok = busy && (stage_oe == 4'b0001);
    cnt = 0;
    while (!done && cnt < 20) begin
      @(negedge clk);
      cnt++;
      if (cnt <= 3 && stage_oe != 4'(1 << cnt)) oe_ok = 0;
      if (cnt == 4 && (stage_oe != 4'b0000 || !busy)) oe_ok = 0;
    end
    exp = model_step(e);
    chk(cnt == 5, "R4", "done latency", cnt, 5);
    chk(oe_ok, "R9", "enable sequence", int'(stage_oe), 0);
    chk($signed(u_out) == exp, req, "u value", $signed(u_out), exp);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt, exp, u_keep;
    rst = 1'b1; ld_gains = 0; start = 0; kp_in = 0; ki_in = 0; kd_in = 0; err_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && u_out == 0 && stage_oe == 0, "R1", "reset state",
        int'(u_out), 0);
    m_kp = 0; m_ki = 0; m_kd = 0; m_em = 0; m_sm = 0;
    sample(50, "R1");                       // gains cleared by reset

    // table walk: R3 R7 R10
    load(5, -3, 7);
    for (int k = 0; k < NTAB; k++) sample(int'(ERR_TAB[k]), "R3 R7 R10");

    // R6: result held while idle
    u_keep = int'(u_out);
    repeat (6) @(negedge clk);
    chk(!done && int'(u_out) == u_keep, "R6", "hold after done", int'(u_out), u_keep);

    // R5: second start mid-run ignored
    @(negedge clk);
    err_in = 8'd20; start = 1'b1;
    @(negedge clk);
    err_in = 8'd99;
    @(negedge clk);
    start = 1'b0;
    cnt = 2;
    while (!done && cnt < 20) begin @(negedge clk); cnt++; end
    exp = model_step(20);
    chk(cnt == 6, "R5", "run length with extra start", cnt, 6);
    chk($signed(u_out) == exp, "R5", "u with extra start", $signed(u_out), exp);
    @(negedge clk);
    @(negedge clk);
    chk(!busy, "R5", "no second run", int'(busy), 0);

    // R2: gain load mid-run ignored, history kept
    @(negedge clk);
    err_in = 8'(-9); start = 1'b1;
    @(negedge clk);
    start = 1'b0; kp_in = 8'd100; ki_in = 8'd100; kd_in = 8'd100; ld_gains = 1'b1;
    @(negedge clk);
    ld_gains = 1'b0;
    while (!done) @(negedge clk);
    exp = model_step(-9);
    chk($signed(u_out) == exp, "R2", "u with busy load", $signed(u_out), exp);
    sample(15, "R2");

    // R2: idle load clears history
    load(2, 1, 3);
    sample(4, "R2 R10");

    // R8: saturation at both limits
    load(0, 1, 0);
    for (int k = 0; k < 20; k++) sample(127, "R8");
    chk($signed(u_out) == SMAXI, "R8", "upper clamp", $signed(u_out), SMAXI);
    for (int k = 0; k < 40; k++) sample(-128, "R8");
    chk($signed(u_out) == -SMAXI - 1, "R8", "lower clamp", $signed(u_out), -SMAXI - 1);

    // random gains and errors: R3 R7
    load($signed(8'($urandom_range(0, 255))), $signed(8'($urandom_range(0, 255))),
         $signed(8'($urandom_range(0, 255))));
    for (int k = 0; k < 30; k++) sample($signed(8'($urandom_range(0, 255))), "R3 R7");

    // R1: reset in mid-run
    @(negedge clk);
    err_in = 8'd30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && u_out == 0 && stage_oe == 0, "R1", "mid-run reset",
        int'(u_out), 0);
    m_kp = 0; m_ki = 0; m_kd = 0; m_em = 0; m_sm = 0;
    sample(-60, "R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule